// File: doc/BRIEF.md
# Lockable Driver Configuration Register File

This block is the configuration and status register bank of a two-channel half-bridge power driver. A simple synchronous bus drives it: an address, a write-data byte, a write strobe and a read strobe. The bank has six byte locations. Two of them are read-only windows onto status bytes that a separate fault supervisor produces. The other four are read/write control bytes, and every field in them is decoded and brought out as a port for the driver logic.

Three special behaviours sit inside the bank. The first is a key field: writing one code into it freezes the control settings, and writing another code releases them. The second is a fault-clear command bit. Writing it sends a one-cycle pulse to the supervisor, and the bit clears itself. The third is an open-load test request bit. Software sets it, it stays set while the test runs, and hardware clears it when the test-done input arrives. Serial framing and the test itself are outside this block.

Top module: `drvcfg_regbank`

## Requirements
- R1: After reset the control bytes read 0x51 at location 2, 0x0C at location 3, 0x40 at location 4 and 0x08 at location 5. Read data is 0x00, the lock is released, and the clear pulse and the test request are low.
- R2: Location 2 decodes as toff[7:6], spi_in[5], slew[4:2] and mode[1:0]. Location 3 decodes as itrip_rep[7], tsd_mode[6], otw_rep[5], cpuv_dis[4], ocp_retry[3:2] and ocp_mode[1:0]. Each field drives its own output port.
- R3: Read data is registered. It appears on the cycle after the read strobe and holds until the next strobe. Location 0 returns the fault status input and location 1 returns the diagnostic status input. Reserved locations (6 and above) read 0x00. Writes to locations 0 and 1 change nothing.
- R4: Location 4 bits [6:4] hold the lock key and are always written. Key 011 engages the lock, key 110 releases it, and any other key is stored without changing the lock state. While the lock is engaged, writes to locations 2, 3 and 5 and to bits [3:0] of location 4 are ignored.
- R5: A write to location 4 with bit 7 set raises clear_pulse_o for exactly the following cycle, whether or not the lock is engaged. Bit 7 then reads 0 without any further write.
- R6: An unlocked write to location 5 with bit 6 set raises the test request, which also reads back in bit 6. Writing 0 to bit 6 does not clear it. The request returns to 0 on the cycle after olp_done_i is high. If a set and olp_done_i arrive in the same cycle, the set wins.
- R7: Writes to reserved locations leave every control byte and every output unchanged.
- R8: Location 5 bit 7 is plain storage. It reads back what was written and drives no output.
- R9: Location 4 decodes as out1_dis[3], out2_dis[2], en_in1[1] and ph_in2[0]. Location 5 decodes as olp_dly[5], ola_en[4], itrip_lvl[3:2] and itrip_dis[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Location address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| fault_stat_i | input | 8 | Fault status byte, read at location 0 |
| diag_stat_i | input | 8 | Diagnostic status byte, read at location 1 |
| olp_done_i | input | 1 | Open-load test finished |
| clear_pulse_o | output | 1 | One-cycle fault clear command |
| olp_req_o | output | 1 | Open-load test request |
| locked_o | output | 1 | Control lock engaged |
| lock_key_o | output | 3 | Stored lock key field |
| toff_o | output | 2 | Off-time select |
| spi_in_o | output | 1 | Bridge inputs taken from register bits |
| slew_o | output | 3 | Slew-rate select |
| mode_o | output | 2 | Bridge control mode |
| itrip_rep_o | output | 1 | Report current regulation as fault |
| tsd_mode_o | output | 1 | Overtemperature auto-recovery |
| otw_rep_o | output | 1 | Report overtemperature warning as fault |
| cpuv_dis_o | output | 1 | Charge-pump undervoltage fault disabled |
| ocp_retry_o | output | 2 | Overcurrent retry time select |
| ocp_mode_o | output | 2 | Overcurrent response mode |
| out1_dis_o | output | 1 | Half bridge 1 disabled |
| out2_dis_o | output | 1 | Half bridge 2 disabled |
| en_in1_o | output | 1 | Register-driven input 1 |
| ph_in2_o | output | 1 | Register-driven input 2 |
| olp_dly_o | output | 1 | Long open-load test delay |
| ola_en_o | output | 1 | Active-mode open-load check enabled |
| itrip_lvl_o | output | 2 | Current regulation level |
| itrip_dis_o | output | 2 | Current regulation disable per output |

## Verification
The bench builds the bank with its default ADDR_W of 4. This gives sixteen addresses, so ten reserved locations can be swept for both read and write. Every one of the 256 byte values is written to each control location. The sweep over location 4 passes through both keys twice, so all four control bytes are exercised in locked and unlocked state against an arithmetic model. The clear pulse, the set-over-done priority of the test request, and the status windows are each checked with directed patterns.

// File: rtl/drvcfg_pkg.sv
package drvcfg_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_LOC  = 6;
  localparam int NUM_CTRL = 4;
  localparam int CTRL_BASE = 2;

  localparam logic [7:0] RST_DRIVE = 8'h51;
  localparam logic [7:0] RST_PROT  = 8'h0C;
  localparam logic [2:0] RST_KEY   = 3'b100;
  localparam logic [7:0] RST_OLT   = 8'h08;

  localparam logic [2:0] KEY_LOCK   = 3'b011;
  localparam logic [2:0] KEY_UNLOCK = 3'b110;

  typedef enum logic [2:0] {
    LOC_FAULT = 3'd0,
    LOC_DIAG  = 3'd1,
    LOC_DRIVE = 3'd2,
    LOC_PROT  = 3'd3,
    LOC_CMD   = 3'd4,
    LOC_OLT   = 3'd5
  } loc_e;

  typedef struct packed {
    logic [1:0] toff;
    logic       spi_in;
    logic [2:0] slew;
    logic [1:0] mode;
  } drive_t;

  typedef struct packed {
    logic       itrip_rep;
    logic       tsd_mode;
    logic       otw_rep;
    logic       cpuv_dis;
    logic [1:0] ocp_retry;
    logic [1:0] ocp_mode;
  } prot_t;

  function automatic logic lock_next(input logic cur, input logic [2:0] key);
    if (key == KEY_LOCK)        return 1'b1;
    else if (key == KEY_UNLOCK) return 1'b0;
    else                        return cur;
  endfunction

  function automatic logic [7:0] plain_reset(input int idx);
    return (idx == 0) ? RST_DRIVE : RST_PROT;
  endfunction

  function automatic logic [7:0] cmd_byte(input logic clr, input logic [2:0] key,
                                          input logic [3:0] lo);
    return {clr, key, lo};
  endfunction
endpackage

// File: rtl/drvcfg_lock.sv
module drvcfg_lock
  import drvcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [2:0] key_in,
  output logic       locked,
  output logic [2:0] key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      key_q  <= RST_KEY;
    end else if (key_wr) begin
      locked <= lock_next(locked, key_in);
      key_q  <= key_in;
    end
  end

  AST_LOCK_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_in == KEY_LOCK |=> locked); // R4
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_in == KEY_UNLOCK |=> !locked); // R4
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_wr && (key_in == KEY_LOCK || key_in == KEY_UNLOCK)) |=> $stable(locked)); // R4
endmodule

// File: rtl/drvcfg_ctrl.sv
module drvcfg_ctrl
  import drvcfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTRL-1:0] ctrl_wr,
  input  logic [7:0]          wdata,
  input  logic                locked,
  input  logic                olp_done,
  output logic [7:0]          drive_q,
  output logic [7:0]          prot_q,
  output logic [3:0]          cmd_lo_q,
  output logic                clr_q,
  output logic                ol_rsvd_q,
  output logic                ol_req_q,
  output logic [5:0]          ol_lo_q
);
  localparam int NUM_PLAIN = 2;
  localparam int IDX_CMD   = int'(LOC_CMD) - CTRL_BASE;
  localparam int IDX_OLT   = int'(LOC_OLT) - CTRL_BASE;

  logic                 allow;
  logic [NUM_PLAIN-1:0][7:0] plain_q;
  logic                 cmd_wr_ok;
  logic                 olt_wr_ok;
  logic                 req_set;

  assign allow     = !locked;
  assign cmd_wr_ok = ctrl_wr[IDX_CMD] && allow;
  assign olt_wr_ok = ctrl_wr[IDX_OLT] && allow;
  assign req_set   = olt_wr_ok && wdata[6];

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       plain_q[g] <= plain_reset(g);
      else if (ctrl_wr[g] && allow)     plain_q[g] <= wdata;
    end
  end

  assign drive_q = plain_q[0];
  assign prot_q  = plain_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_lo_q  <= 4'h0;
      clr_q     <= 1'b0;
      ol_rsvd_q <= RST_OLT[7];
      ol_lo_q   <= RST_OLT[5:0];
      ol_req_q  <= RST_OLT[6];
    end else begin
      clr_q <= ctrl_wr[IDX_CMD] && wdata[7];
      if (cmd_wr_ok) cmd_lo_q <= wdata[3:0];
      if (olt_wr_ok) begin
        ol_rsvd_q <= wdata[7];
        ol_lo_q   <= wdata[5:0];
      end
      if (req_set)       ol_req_q <= 1'b1;
      else if (olp_done) ol_req_q <= 1'b0;
    end
  end

  AST_LOCKED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    locked && ctrl_wr[0] |=> $stable(drive_q)); // R4
  AST_LOCKED_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    locked && ctrl_wr[1] |=> $stable(prot_q)); // R4
  AST_LOCKED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    locked && ctrl_wr[IDX_CMD] |=> $stable(cmd_lo_q)); // R4
  AST_OLP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> ol_req_q); // R6
  AST_OLP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ol_req_q) |-> $past(olp_done)); // R6
  AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q && !ctrl_wr[IDX_CMD] |=> !clr_q); // R5
endmodule

// File: rtl/drvcfg_rdport.sv
module drvcfg_rdport
  import drvcfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic                         rd_ok,
  input  logic [2:0]                   rd_loc,
  input  logic [NUM_LOC-1:0][DATA_W-1:0] bytes_in,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (rd_ok && rd_loc == 3'(i)) sel_byte = bytes_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_byte;
  end

  AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_ok |=> rdata == '0); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R3
endmodule

// File: rtl/drvcfg_regbank.sv
module drvcfg_regbank
  import drvcfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        fault_stat_i,
  input  logic [7:0]        diag_stat_i,
  input  logic              olp_done_i,
  output logic              clear_pulse_o,
  output logic              olp_req_o,
  output logic              locked_o,
  output logic [2:0]        lock_key_o,
  output logic [1:0]        toff_o,
  output logic              spi_in_o,
  output logic [2:0]        slew_o,
  output logic [1:0]        mode_o,
  output logic              itrip_rep_o,
  output logic              tsd_mode_o,
  output logic              otw_rep_o,
  output logic              cpuv_dis_o,
  output logic [1:0]        ocp_retry_o,
  output logic [1:0]        ocp_mode_o,
  output logic              out1_dis_o,
  output logic              out2_dis_o,
  output logic              en_in1_o,
  output logic              ph_in2_o,
  output logic              olp_dly_o,
  output logic              ola_en_o,
  output logic [1:0]        itrip_lvl_o,
  output logic [1:0]        itrip_dis_o
);
  localparam logic [ADDR_W-1:0] LOC_LIMIT = ADDR_W'(NUM_LOC);

  logic                 addr_ok;
  logic [2:0]           loc;
  logic [NUM_LOC-1:0]   wr_sel;
  logic [NUM_CTRL-1:0]  ctrl_wr;
  logic                 locked;
  logic [2:0]           key_q;
  logic [7:0]           drive_q;
  logic [7:0]           prot_q;
  logic [3:0]           cmd_lo_q;
  logic                 clr_q;
  logic                 ol_rsvd_q;
  logic                 ol_req_q;
  logic [5:0]           ol_lo_q;
  logic [NUM_LOC-1:0][7:0] rd_bytes;
  drive_t               drv;
  prot_t                prt;

  assign addr_ok = bus_addr < LOC_LIMIT;
  assign loc     = bus_addr[2:0];

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_dec
    assign wr_sel[i] = bus_we && addr_ok && (loc == 3'(i));
  end
  assign ctrl_wr = wr_sel[NUM_LOC-1:CTRL_BASE];

  drvcfg_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_wr (wr_sel[LOC_CMD]),
    .key_in (bus_wdata[6:4]),
    .locked (locked),
    .key_q  (key_q)
  );

  drvcfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .wdata     (bus_wdata),
    .locked    (locked),
    .olp_done  (olp_done_i),
    .drive_q   (drive_q),
    .prot_q    (prot_q),
    .cmd_lo_q  (cmd_lo_q),
    .clr_q     (clr_q),
    .ol_rsvd_q (ol_rsvd_q),
    .ol_req_q  (ol_req_q),
    .ol_lo_q   (ol_lo_q)
  );

  assign rd_bytes[LOC_FAULT] = fault_stat_i;
  assign rd_bytes[LOC_DIAG]  = diag_stat_i;
  assign rd_bytes[LOC_DRIVE] = drive_q;
  assign rd_bytes[LOC_PROT]  = prot_q;
  assign rd_bytes[LOC_CMD]   = cmd_byte(clr_q, key_q, cmd_lo_q);
  assign rd_bytes[LOC_OLT]   = {ol_rsvd_q, ol_req_q, ol_lo_q};

  drvcfg_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_re),
    .rd_ok    (addr_ok),
    .rd_loc   (loc),
    .bytes_in (rd_bytes),
    .rdata    (bus_rdata)
  );

  assign drv = drive_t'(drive_q);
  assign prt = prot_t'(prot_q);

  assign clear_pulse_o = clr_q;
  assign olp_req_o     = ol_req_q;
  assign locked_o      = locked;
  assign lock_key_o    = key_q;
  assign toff_o        = drv.toff;
  assign spi_in_o      = drv.spi_in;
  assign slew_o        = drv.slew;
  assign mode_o        = drv.mode;
  assign itrip_rep_o   = prt.itrip_rep;
  assign tsd_mode_o    = prt.tsd_mode;
  assign otw_rep_o     = prt.otw_rep;
  assign cpuv_dis_o    = prt.cpuv_dis;
  assign ocp_retry_o   = prt.ocp_retry;
  assign ocp_mode_o    = prt.ocp_mode;
  assign out1_dis_o    = cmd_lo_q[3];
  assign out2_dis_o    = cmd_lo_q[2];
  assign en_in1_o      = cmd_lo_q[1];
  assign ph_in2_o      = cmd_lo_q[0];
  assign olp_dly_o     = ol_lo_q[5];
  assign ola_en_o      = ol_lo_q[4];
  assign itrip_lvl_o   = ol_lo_q[3:2];
  assign itrip_dis_o   = ol_lo_q[1:0];

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse_o |-> $past(bus_we && addr_ok && loc == LOC_CMD && bus_wdata[7])); // R5
  AST_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !addr_ok |=> $stable({drive_q, prot_q, cmd_lo_q, key_q, locked, ol_rsvd_q, ol_lo_q})); // R7
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[LOC_FAULT] || wr_sel[LOC_DIAG]) |=> $stable({drive_q, prot_q, cmd_lo_q, key_q, locked, ol_rsvd_q, ol_lo_q})); // R3
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R7
endmodule

// File: tb/drvcfg_regbank_tb.sv
`timescale 1ns/1ps
module drvcfg_regbank_tb;
  localparam int ADDR_W = 4;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] fault_stat_i = '0, diag_stat_i = '0;
  logic olp_done_i = 1'b0;
  logic clear_pulse_o, olp_req_o, locked_o;
  logic [2:0] lock_key_o, slew_o;
  logic [1:0] toff_o, mode_o, ocp_retry_o, ocp_mode_o, itrip_lvl_o, itrip_dis_o;
  logic spi_in_o, itrip_rep_o, tsd_mode_o, otw_rep_o, cpuv_dis_o;
  logic out1_dis_o, out2_dis_o, en_in1_o, ph_in2_o, olp_dly_o, ola_en_o;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [7:0] m_drive, m_prot;
  logic [3:0] m_cmdlo;
  logic [2:0] m_key;
  logic m_lock, m_rsvd5, m_req;
  logic [5:0] m_ollo;

  always #10 clk = ~clk;

  drvcfg_regbank #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .fault_stat_i(fault_stat_i), .diag_stat_i(diag_stat_i), .olp_done_i(olp_done_i),
    .clear_pulse_o(clear_pulse_o), .olp_req_o(olp_req_o), .locked_o(locked_o),
    .lock_key_o(lock_key_o), .toff_o(toff_o), .spi_in_o(spi_in_o), .slew_o(slew_o),
    .mode_o(mode_o), .itrip_rep_o(itrip_rep_o), .tsd_mode_o(tsd_mode_o),
    .otw_rep_o(otw_rep_o), .cpuv_dis_o(cpuv_dis_o), .ocp_retry_o(ocp_retry_o),
    .ocp_mode_o(ocp_mode_o), .out1_dis_o(out1_dis_o), .out2_dis_o(out2_dis_o),
    .en_in1_o(en_in1_o), .ph_in2_o(ph_in2_o), .olp_dly_o(olp_dly_o),
    .ola_en_o(ola_en_o), .itrip_lvl_o(itrip_lvl_o), .itrip_dis_o(itrip_dis_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    case (a)
      0: return fault_stat_i;
      1: return diag_stat_i;
      2: return m_drive;
      3: return m_prot;
      4: return {1'b0, m_key, m_cmdlo};
      5: return {m_rsvd5, m_req, m_ollo};
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input int a);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("read loc %0d", a), d, exp_byte(a));
  endtask

  task automatic chk_outputs(input string tag);
    chk("R2", {tag, " toff"},  {6'b0, toff_o},   {6'b0, m_drive[7:6]});
    chk("R2", {tag, " spi_in"}, {7'b0, spi_in_o}, {7'b0, m_drive[5]});
    chk("R2", {tag, " slew"},  {5'b0, slew_o},   {5'b0, m_drive[4:2]});
    chk("R2", {tag, " mode"},  {6'b0, mode_o},   {6'b0, m_drive[1:0]});
    chk("R2", {tag, " prot"}, {itrip_rep_o, tsd_mode_o, otw_rep_o, cpuv_dis_o,
        ocp_retry_o, ocp_mode_o}, m_prot);
    chk("R9", {tag, " cmd lo"}, {4'b0, out1_dis_o, out2_dis_o, en_in1_o, ph_in2_o},
        {4'b0, m_cmdlo});
    chk("R9", {tag, " olt lo"}, {2'b0, olp_dly_o, ola_en_o, itrip_lvl_o, itrip_dis_o},
        {2'b0, m_ollo});
    chk("R4", {tag, " lock"}, {4'b0, lock_key_o, locked_o}, {4'b0, m_key, m_lock});
    chk("R6", {tag, " req"}, {7'b0, olp_req_o}, {7'b0, m_req});
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic unl;
    unl = !m_lock;
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      2: if (unl) m_drive = d;
      3: if (unl) m_prot = d;
      4: begin
        m_key = d[6:4];
        if (unl) m_cmdlo = d[3:0];
        if (d[6:4] == 3'b011) m_lock = 1'b1;
        else if (d[6:4] == 3'b110) m_lock = 1'b0;
      end
      5: if (unl) begin
        m_rsvd5 = d[7]; m_ollo = d[5:0];
        if (d[6]) m_req = 1'b1;
      end
      default: ;
    endcase
    chk("R5", "clear pulse after write", {7'b0, clear_pulse_o},
        {7'b0, (a == 4) && d[7]});
    if (a == 4 && d[7]) begin
      @(negedge clk);
      chk("R5", "clear pulse one cycle", {7'b0, clear_pulse_o}, 8'h00);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); olp_done_i = 1'b1;
    @(negedge clk); olp_done_i = 1'b0;
    m_req = 1'b0;
    chk("R6", "request cleared by done", {7'b0, olp_req_o}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    m_drive = 8'h51; m_prot = 8'h0C; m_cmdlo = 4'h0; m_key = 3'b100;
    m_lock = 1'b0; m_rsvd5 = 1'b0; m_req = 1'b0; m_ollo = 6'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rdata at reset", bus_rdata, 8'h00);
    chk("R1", "clear pulse at reset", {7'b0, clear_pulse_o}, 8'h00);
    chk_outputs("R1 reset");
    rd_chk("R1", 2); rd_chk("R1", 3); rd_chk("R1", 4); rd_chk("R1", 5);
    chk("R1", "explicit loc2", exp_byte(2), 8'h51);

    // R3 read data holds after strobe
    rd(2, d);
    @(negedge clk);
    chk("R3", "rdata holds", bus_rdata, d);

    // R2 R8 R9 R6: full value sweeps of plain control bytes
    foreach (m_drive[i]) ;
    for (int a = 2; a <= 5; a++) begin
      if (a == 4) continue;
      for (int v = 0; v < 256; v++) begin
        wr(a, 8'(v));
        rd_chk(a == 5 ? "R8" : "R2", a);
        chk_outputs("sweep");
        if (m_req) pulse_done();
      end
    end

    // R4 R5 R9: sweep of the command byte passes through both keys
    for (int v = 0; v < 256; v++) begin
      wr(4, 8'(v));
      rd_chk("R5", 4);
      chk_outputs("R4 cmd sweep");
    end

    // R4: locked writes to other locations ignored
    wr(4, 8'h30);
    chk("R4", "locked after key", {7'b0, locked_o}, 8'h01);
    for (int v = 0; v < 256; v += 17) begin
      wr(2, 8'(v)); wr(3, 8'(v)); wr(5, 8'(v) | 8'h40);
      rd_chk("R4", 2); rd_chk("R4", 3); rd_chk("R4", 5);
      chk_outputs("R4 locked");
    end
    wr(4, 8'hA5);
    chk_outputs("R4 clear while locked");
    wr(4, 8'h60);
    chk("R4", "released", {7'b0, locked_o}, 8'h00);

    // R6: set and done together, set wins
    @(negedge clk);
    bus_addr = ADDR_W'(5); bus_wdata = 8'h40; bus_we = 1'b1; olp_done_i = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; olp_done_i = 1'b0;
    m_req = 1'b1; m_rsvd5 = 1'b0; m_ollo = 6'h00;
    chk("R6", "set beats done", {7'b0, olp_req_o}, 8'h01);
    wr(5, 8'h00);
    chk("R6", "zero write keeps request", {7'b0, olp_req_o}, 8'h01);
    rd_chk("R6", 5);
    pulse_done();

    // R7: reserved writes, R3: status writes
    for (int a = 0; a < NADDR; a++) begin
      if (a >= 2 && a <= 5) continue;
      wr(a, 8'hFF);
      chk_outputs(a < 2 ? "R3 status write" : "R7 reserved write");
      for (int b = 0; b < NADDR; b++) rd_chk(a < 2 ? "R3" : "R7", b);
    end

    // R3: status windows
    for (int i = 0; i < 16; i++) begin
      fault_stat_i = 8'(i * 17);
      diag_stat_i  = ~8'(i * 13);
      rd_chk("R3", 0);
      rd_chk("R3", 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule